// File: doc/BRIEF.md
# Multi-mode 8-bit timer and waveform generator

This block is an 8-bit up/down counter with two compare channels, A and B. Each channel drives one waveform pin and raises one sticky match flag. A 3-bit mode code picks the counter's behaviour. The same code also sets three other things:

- the TOP value the counter turns at (fixed all-ones, or the live compare A value);
- when a written compare value reaches the active compare register;
- which counter event raises the overflow flag.

The four behaviours are free-running count, clear-on-compare-A, single-slope (fast) PWM and dual-slope (phase-correct) PWM. The counter advances once per clock.

Software reaches the block through a narrow write port with four registers:

- a control register holding the mode code and a 2-bit action field per channel;
- one compare buffer per channel;
- a command register whose bits clear flags (write a one to clear) and fire per-channel force strobes.

The force strobes act only in the two non-PWM modes. Each strobe applies its channel's action to the pin without touching the flags or the counter.

Top module: `wavetimer8`

## Requirements
- R1: Reset (rst_n low) clears the counter, both pins, all three flags, both compare values, both action fields and the mode code. Counting starts on the third rising clock edge after rst_n goes high.
- R2: A write (wr_en high) takes effect on the next clock edge. During that edge the counter and channels still use the old mode. The address map is:
  - address 0 is control: bits 2:0 mode, bits 4:3 channel A action, bits 6:5 channel B action;
  - address 1 is the compare A buffer;
  - address 2 is the compare B buffer;
  - address 3 is command: bit 0 clears overflow, bit 1 clears the A flag, bit 2 clears the B flag, bit 4 forces A, bit 5 forces B.
- R3: Mode 0 counts up and wraps from 255 to 0. The overflow flag rises on the edge that leaves 255. A compare write reaches the active register on the same edge.
- R4: Mode 2 sends the counter to 0 on the edge after it equals compare A. Compare writes act at once. Overflow rises only on an edge that leaves 255.
- R5: Fast PWM wraps to 0 on the edge after the counter equals TOP. TOP is 255 in mode 3 and compare A in mode 7. That wrap edge copies both buffers into the active compare registers. Overflow rises on an edge leaving 255 in mode 3, and on the wrap edge in mode 7.
- R6: Phase-correct PWM counts up to TOP, then down to 0, then back up. TOP is 255 in mode 1 and compare A in mode 5. The edge that turns the counter at TOP copies both buffers. Overflow rises on the edge that turns the counter at 0 while it is counting down.
- R7: In modes 0 and 2, a channel whose counter equals its compare value updates its pin on the next edge. The update depends on the action code:
  - 00 leaves the pin alone;
  - 01 toggles it;
  - 10 clears it;
  - 11 sets it.
- R8: In fast PWM, action 10 sets the pin at the wrap and clears it on a match. Action 11 does the opposite. The wrap wins when both fall on the same edge. Actions 00 and 01 leave the pin alone.
- R9: In phase-correct PWM, action 10 clears the pin on a match while counting up and sets it on a match while counting down. Action 11 does the opposite. Actions 00 and 01 leave the pin alone.
- R10: In every non-reserved mode, a match sets the channel's flag. Flags stay set until a one is written to their clear bit. If a set and a clear fall on the same edge, the set wins.
- R11: A force strobe in mode 0 or 2 applies the channel's action to its pin on the next edge. It does not set a flag and does not restart the counter. In the PWM and reserved modes the strobe has no effect.
- R12: Modes 4 and 6 freeze the counter, its direction, both pins and both active compare values, and no flag is set. Register writes and flag clears are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps once per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 compare A, 2 compare B, 3 command) |
| wr_data | input | 8 | Register write data |
| cnt_o | output | 8 | Current counter value |
| wave_a_o | output | 1 | Channel A waveform pin |
| wave_b_o | output | 1 | Channel B waveform pin |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmpa_flag_o | output | 1 | Sticky channel A match flag |
| cmpb_flag_o | output | 1 | Sticky channel B match flag |

## Verification
Every mode is run long enough to complete several full periods. Channel A uses the non-inverting action and channel B the inverting one, so any swap of pin polarity or count direction shows up as a mismatch on the first match. Compare values are rewritten in the middle of a period in each mode, which separates immediate update from update at TOP or at the wrap, and also shows which edge the new TOP takes hold. The corner values 0 and 255 are tried in the fast modes, where the wrap-wins rule and the single-cycle pulse become visible. Force strobes are fired in CTC, fast PWM and reserved modes to show they act only in the non-PWM modes and never set a flag or restart the counter.

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;

  localparam int unsigned MODE_W = 3;
  localparam int unsigned ACT_W  = 2;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd3;

  localparam int unsigned CMD_CLR_OVF = 0;
  localparam int unsigned CMD_CLR_CH0 = 1;
  localparam int unsigned CMD_FRC_CH0 = 4;

  localparam int unsigned CTRL_ACT_LSB = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_FREE    = 3'd0,
    MODE_DUAL_FF = 3'd1,
    MODE_CTC     = 3'd2,
    MODE_FAST_FF = 3'd3,
    MODE_RSV_A   = 3'd4,
    MODE_DUAL_A  = 3'd5,
    MODE_RSV_B   = 3'd6,
    MODE_FAST_A  = 3'd7
  } tmr_mode_e;

  typedef struct packed {
    logic rsv;
    logic nonpwm;
    logic fast;
    logic dual;
    logic top_is_a;
    logic ovf_at_top;
  } mode_attr_t;

  function automatic mode_attr_t decode_mode(logic [MODE_W-1:0] code);
    mode_attr_t a;
    a = '0;
    case (tmr_mode_e'(code))
      MODE_FREE:    a.nonpwm = 1'b1;
      MODE_CTC:     begin a.nonpwm = 1'b1; a.top_is_a = 1'b1; end
      MODE_FAST_FF: a.fast = 1'b1;
      MODE_FAST_A:  begin a.fast = 1'b1; a.top_is_a = 1'b1; a.ovf_at_top = 1'b1; end
      MODE_DUAL_FF: a.dual = 1'b1;
      MODE_DUAL_A:  begin a.dual = 1'b1; a.top_is_a = 1'b1; end
      default:      a.rsv = 1'b1;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/wtmr_regif.sv
module wtmr_regif
  import wtmr_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned NUM_CH = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DW-1:0]                 wr_data,
  output logic [MODE_W-1:0]             mode_q,
  output logic [NUM_CH-1:0][ACT_W-1:0]  act_q,
  output logic [NUM_CH-1:0]             buf_we,
  output logic [NUM_CH-1:0]             force_p,
  output logic [NUM_CH-1:0]             flag_clr,
  output logic                          ovf_clr
);

  logic                         ctrl_we;
  logic                         cmd_we;
  logic [MODE_W-1:0]            mode_d;
  logic [NUM_CH-1:0][ACT_W-1:0] act_d;

  assign ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
  assign cmd_we  = wr_en && (wr_addr == ADDR_CMD);
  assign ovf_clr = cmd_we && wr_data[CMD_CLR_OVF];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign buf_we[c]   = wr_en && (wr_addr == ADDR_W'(ADDR_CMPA + c));
    assign force_p[c]  = cmd_we && wr_data[CMD_FRC_CH0 + c];
    assign flag_clr[c] = cmd_we && wr_data[CMD_CLR_CH0 + c];
  end

  always_comb begin
    mode_d = mode_q;
    act_d  = act_q;
    if (ctrl_we) begin
      mode_d = wr_data[MODE_W-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        act_d[c] = wr_data[CTRL_ACT_LSB + ACT_W*c +: ACT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      act_q  <= '0;
    end else if (ctrl_we) begin
      mode_q <= mode_d;
      act_q  <= act_d;
    end
  end

endmodule

// File: rtl/wtmr_seq.sv
module wtmr_seq
  import wtmr_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_attr_t    attr,
  input  logic [CW-1:0] top_val,
  input  logic          ovf_clr,
  output logic [CW-1:0] cnt_q,
  output logic          up_q,
  output logic          at_top,
  output logic          copy_evt,
  output logic          ovf_q
);

  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] cnt_d;
  logic          up_d;
  logic          ovf_evt;
  logic          ovf_d;
  logic          at_bot;
  logic          run_en;

  assign at_top = (cnt_q == top_val);
  assign at_bot = (cnt_q == '0);
  assign run_en = !attr.rsv;

  always_comb begin
    copy_evt = 1'b0;
    if (attr.fast) copy_evt = at_top;
    if (attr.dual) copy_evt = up_q && at_top;
  end

  always_comb begin
    ovf_evt = 1'b0;
    if (attr.nonpwm || attr.fast) begin
      ovf_evt = attr.ovf_at_top ? at_top : (cnt_q == CNT_MAX);
    end else if (attr.dual) begin
      ovf_evt = !up_q && at_bot;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (attr.dual) begin
      if (up_q) begin
        if (at_top) begin
          up_d  = 1'b0;
          cnt_d = at_bot ? '0 : cnt_q - CNT_ONE;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end else begin
        if (at_bot) begin
          up_d  = 1'b1;
          cnt_d = at_top ? '0 : CNT_ONE;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
    end else begin
      up_d  = 1'b1;
      cnt_d = at_top ? '0 : cnt_q + CNT_ONE;
    end
  end

  assign ovf_d = ovf_evt || (ovf_q && !ovf_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (run_en) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

endmodule

// File: rtl/wtmr_chan.sv
module wtmr_chan
  import wtmr_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_attr_t       attr,
  input  logic [CW-1:0]    cnt,
  input  logic             up,
  input  logic             at_top,
  input  logic             copy_evt,
  input  logic             buf_we,
  input  logic [CW-1:0]    buf_wdata,
  input  logic [ACT_W-1:0] act,
  input  logic             force_p,
  input  logic             flag_clr,
  output logic [CW-1:0]    cmp_act_q,
  output logic             wave_q,
  output logic             flag_q
);

  logic [CW-1:0] buf_q;
  logic [CW-1:0] buf_d;
  logic [CW-1:0] cmp_d;
  logic          match;
  logic          wave_d;
  logic          flag_d;
  logic          hit;

  assign match = (cnt == cmp_act_q);
  assign buf_d = buf_we ? buf_wdata : buf_q;

  always_comb begin
    cmp_d = cmp_act_q;
    if (attr.nonpwm)  cmp_d = buf_d;
    else if (copy_evt) cmp_d = buf_q;
  end

  assign hit = match || (force_p && attr.nonpwm);

  always_comb begin
    wave_d = wave_q;
    if (attr.nonpwm) begin
      if (hit) begin
        case (act)
          2'b01:   wave_d = !wave_q;
          2'b10:   wave_d = 1'b0;
          2'b11:   wave_d = 1'b1;
          default: wave_d = wave_q;
        endcase
      end
    end else if (attr.fast) begin
      if (act[1]) begin
        if (at_top)     wave_d = !act[0];
        else if (match) wave_d = act[0];
      end
    end else if (attr.dual) begin
      if (act[1] && match) wave_d = up ? act[0] : !act[0];
    end
  end

  assign flag_d = (match && !attr.rsv) || (flag_q && !flag_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_we) begin
      buf_q <= buf_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act_q <= '0;
      wave_q    <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      cmp_act_q <= cmp_d;
      wave_q    <= wave_d;
      flag_q    <= flag_d;
    end
  end

endmodule

// File: rtl/wavetimer8.sv
module wavetimer8
  import wtmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wave_a_o,
  output logic              wave_b_o,
  output logic              ovf_flag_o,
  output logic              cmpa_flag_o,
  output logic              cmpb_flag_o
);

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0]            rst_sync_q;
  logic                         rst_n_s;
  logic [MODE_W-1:0]            cur_mode;
  mode_attr_t                   attr;
  logic [NUM_CH-1:0][ACT_W-1:0] ch_act;
  logic [NUM_CH-1:0]            buf_we;
  logic [NUM_CH-1:0]            force_p;
  logic [NUM_CH-1:0]            flag_clr;
  logic                         ovf_clr;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
  logic [NUM_CH-1:0]            wave;
  logic [NUM_CH-1:0]            flag;
  logic [CNT_W-1:0]             cnt;
  logic [CNT_W-1:0]             top_val;
  logic                         up;
  logic                         at_top;
  logic                         copy_evt;
  logic                         ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_N-1];

  wtmr_regif #(.DW(CNT_W), .NUM_CH(NUM_CH)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mode_q   (cur_mode),
    .act_q    (ch_act),
    .buf_we   (buf_we),
    .force_p  (force_p),
    .flag_clr (flag_clr),
    .ovf_clr  (ovf_clr)
  );

  assign attr    = decode_mode(cur_mode);
  assign top_val = attr.top_is_a ? cmp_act[0] : '1;

  wtmr_seq #(.CW(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .attr     (attr),
    .top_val  (top_val),
    .ovf_clr  (ovf_clr),
    .cnt_q    (cnt),
    .up_q     (up),
    .at_top   (at_top),
    .copy_evt (copy_evt),
    .ovf_q    (ovf)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    wtmr_chan #(.CW(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .attr      (attr),
      .cnt       (cnt),
      .up        (up),
      .at_top    (at_top),
      .copy_evt  (copy_evt),
      .buf_we    (buf_we[c]),
      .buf_wdata (wr_data),
      .act       (ch_act[c]),
      .force_p   (force_p[c]),
      .flag_clr  (flag_clr[c]),
      .cmp_act_q (cmp_act[c]),
      .wave_q    (wave[c]),
      .flag_q    (flag[c])
    );
  end

  assign cnt_o       = cnt;
  assign wave_a_o    = wave[0];
  assign wave_b_o    = wave[1];
  assign ovf_flag_o  = ovf;
  assign cmpa_flag_o = flag[0];
  assign cmpb_flag_o = flag[1];

endmodule

// File: rtl/wtmr_chk.sv
module wtmr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic [1:0] act_a,
  input logic [7:0] cnt,
  input logic [7:0] ocra_act,
  input logic       wave_a,
  input logic       ovf,
  input logic       fa,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data
);

  logic cmd_wr;
  assign cmd_wr = wr_en && (wr_addr == 2'd3);

  // R3: free-running mode steps by one and wraps
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |=> (cnt == $past(cnt) + 8'd1));

  // R4: clear-on-compare returns to zero after matching compare A
  p_ctc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && cnt == ocra_act) |=> (cnt == 8'd0));

  // R8: wrap edge sets a non-inverting fast PWM pin
  p_fast_bottom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && cnt == 8'hFF && act_a == 2'b10) |=> wave_a);

  // R10: overflow flag stays until cleared
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(cmd_wr && wr_data[0])) |=> ovf);

  // R11: a force strobe never raises the match flag
  p_force_noflag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data[4] && cnt != ocra_act && !fa) |=> !fa);

  // R12: reserved modes freeze counter and pin
  p_rsv_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 || mode == 3'd6) |=> ($stable(cnt) && $stable(wave_a)));

endmodule

bind wavetimer8 wtmr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .mode     (cur_mode),
  .act_a    (ch_act[0]),
  .cnt      (cnt_o),
  .ocra_act (cmp_act[0]),
  .wave_a   (wave_a_o),
  .ovf      (ovf_flag_o),
  .fa       (cmpa_flag_o),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/tb_wavetimer8.sv
`timescale 1ns/1ps
module tb_wavetimer8;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] cnt_o;
  logic       wave_a_o, wave_b_o, ovf_flag_o, cmpa_flag_o, cmpb_flag_o;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  // reference model state
  int m_mode, m_cnt, m_up, m_ovf;
  int m_buf[2], m_cmp[2], m_w[2], m_f[2], m_act[2];

  wavetimer8 dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt_o), .wave_a_o(wave_a_o), .wave_b_o(wave_b_o),
    .ovf_flag_o(ovf_flag_o), .cmpa_flag_o(cmpa_flag_o), .cmpb_flag_o(cmpb_flag_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "cnt",    int'(cnt_o),       m_cnt);
    chk(cur_req, "wave_a", int'(wave_a_o),    m_w[0]);
    chk(cur_req, "wave_b", int'(wave_b_o),    m_w[1]);
    chk(cur_req, "ovf",    int'(ovf_flag_o),  m_ovf);
    chk(cur_req, "flag_a", int'(cmpa_flag_o), m_f[0]);
    chk(cur_req, "flag_b", int'(cmpb_flag_o), m_f[1]);
  endtask

  task automatic model_reset();
    m_mode = 0; m_cnt = 0; m_up = 1; m_ovf = 0;
    for (int c = 0; c < 2; c++) begin
      m_buf[c] = 0; m_cmp[c] = 0; m_w[c] = 0; m_f[c] = 0; m_act[c] = 0;
    end
  endtask

  // One clock edge of behaviour, from the requirements.
  task automatic model_step(input bit we, input int a, input int d);
    bit rsv, dual, fast, nonpwm, at_top, match, ovf_set;
    int top, cmd, nb, ncnt, nup;
    int old_buf[2];
    rsv    = (m_mode == 4) || (m_mode == 6);
    dual   = (m_mode == 1) || (m_mode == 5);
    fast   = (m_mode == 3) || (m_mode == 7);
    nonpwm = (m_mode == 0) || (m_mode == 2);
    top    = (m_mode == 2 || m_mode == 5 || m_mode == 7) ? m_cmp[0] : 255;
    at_top = (m_cnt == top);
    cmd    = (we && a == 3) ? d : 0;
    for (int c = 0; c < 2; c++) begin
      old_buf[c] = m_buf[c];
      nb = (we && a == 1 + c) ? d : m_buf[c];
      match = (m_cnt == m_cmp[c]);
      if (nonpwm) begin
        if (match || cmd[4+c]) begin
          if (m_act[c] == 1) m_w[c] = 1 - m_w[c];
          else if (m_act[c] == 2) m_w[c] = 0;
          else if (m_act[c] == 3) m_w[c] = 1;
        end
      end else if (fast && m_act[c] >= 2) begin
        if (at_top)     m_w[c] = (m_act[c] == 2) ? 1 : 0;
        else if (match) m_w[c] = (m_act[c] == 2) ? 0 : 1;
      end else if (dual && m_act[c] >= 2 && match) begin
        if (m_up == 1) m_w[c] = (m_act[c] == 2) ? 0 : 1;
        else           m_w[c] = (m_act[c] == 2) ? 1 : 0;
      end
      m_f[c] = ((match && !rsv) || (m_f[c] == 1 && !cmd[1+c])) ? 1 : 0;
      if (nonpwm) m_cmp[c] = nb;
      else if ((fast && at_top) || (dual && m_up == 1 && at_top)) m_cmp[c] = old_buf[c];
      m_buf[c] = nb;
    end
    ovf_set = 0;
    if (nonpwm || m_mode == 3) ovf_set = (m_cnt == 255);
    else if (m_mode == 7)      ovf_set = at_top;
    else if (dual)             ovf_set = (m_up == 0 && m_cnt == 0);
    m_ovf = (ovf_set || (m_ovf == 1 && !cmd[0])) ? 1 : 0;
    ncnt = m_cnt; nup = m_up;
    if (!rsv) begin
      if (dual) begin
        if (m_up == 1) begin
          if (at_top) begin nup = 0; ncnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else ncnt = (m_cnt + 1) & 255;
        end else begin
          if (m_cnt == 0) begin nup = 1; ncnt = at_top ? 0 : 1; end
          else ncnt = m_cnt - 1;
        end
      end else begin
        nup = 1;
        ncnt = at_top ? 0 : ((m_cnt + 1) & 255);
      end
    end
    m_cnt = ncnt; m_up = nup;
    if (we && a == 0) begin
      m_mode = d & 7; m_act[0] = (d >> 3) & 3; m_act[1] = (d >> 5) & 3;
    end
  endtask

  task automatic tick(input bit we, input int a, input int d);
    wr_en = we; wr_addr = a[1:0]; wr_data = d[7:0];
    @(posedge clk);
    #1;
    model_step(we, a, d);
    compare_all();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int cnt_before;
    wr_en = 0; wr_addr = 0; wr_data = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    cur_req = "R1"; compare_all();

    // mode 0, register writes
    cur_req = "R2";
    tick(1, 1, 8'h05);
    tick(1, 2, 8'h80);
    tick(1, 0, 8'h68);              // act_b=11, act_a=01, mode 0
    cur_req = "R7"; run(40);
    cur_req = "R3"; run(300);
    cur_req = "R10"; tick(1, 3, 8'h07); run(3);
    tick(1, 3, 8'h07);

    // force in free-running mode
    cur_req = "R11";
    tick(1, 0, 8'h50);              // act_b=10, act_a=10
    tick(1, 3, 8'h10);
    tick(1, 0, 8'h28);              // toggle both
    tick(1, 3, 8'h30); run(5);

    // clear-on-compare
    cur_req = "R4";
    tick(1, 1, 8'h09);
    tick(1, 0, 8'h2A);
    run(40);
    cur_req = "R11";
    tick(1, 3, 8'h10);
    chk("R11", "flag_a after force", int'(cmpa_flag_o), m_f[0]);
    cnt_before = int'(cnt_o);
    tick(1, 3, 8'h10);
    chk("R11", "cnt not restarted", int'(cnt_o), (cnt_before == 9) ? 0 : cnt_before + 1);
    run(20);
    cur_req = "R4";
    run(5); tick(1, 1, 8'h03);
    run(300);
    cur_req = "R10"; tick(1, 3, 8'h07);

    // fast PWM, TOP = 255
    cur_req = "R8";
    tick(1, 1, 8'h40); tick(1, 2, 8'h20);
    tick(1, 0, 8'h73);
    run(300);
    cur_req = "R5";
    run(100); tick(1, 1, 8'h90);
    run(300);
    cur_req = "R11"; tick(1, 3, 8'h30); run(10);
    cur_req = "R8";
    tick(1, 1, 8'hFF); run(600);
    tick(1, 1, 8'h00); run(300);

    // fast PWM, TOP = compare A
    cur_req = "R5";
    tick(1, 1, 8'd20); tick(1, 2, 8'd7);
    tick(1, 0, 8'h77);
    run(60); tick(1, 1, 8'd10); run(60);
    tick(1, 2, 8'd0); run(50);
    cur_req = "R10"; tick(1, 3, 8'h07); run(30);

    // phase correct
    cur_req = "R9";
    tick(1, 1, 8'h30); tick(1, 2, 8'hC0);
    tick(1, 0, 8'h71);
    run(1100);
    cur_req = "R6";
    tick(1, 1, 8'd40); tick(1, 2, 8'd10);
    tick(1, 0, 8'h75);
    run(200); tick(1, 1, 8'd25); run(200);

    // reserved modes
    cur_req = "R12";
    tick(1, 0, 8'h74); run(20);
    tick(1, 1, 8'h33); tick(1, 3, 8'h37); run(5);
    tick(1, 0, 8'h76); run(10);
    tick(1, 0, 8'h70); run(30);

    finish_run();
  end

endmodule